// File: doc/BRIEF.md
# TDM Timeslot Bit-Insertion Selector

This block works on a 2.048 Mb/s serial E1 stream. For each bit clock it decides whether the outgoing bit comes from the payload input or from an HDLC transmitter. A frame is 32 timeslots of 8 bits, and a frame-sync pulse marks its first bit. The block keeps its own bit-position and frame-parity state from that pulse. A bit is given to the HDLC source only when three conditions all hold: the frame parity is one the channel accepts, the bit lies in the chosen timeslot, and the mask allows that bit of the timeslot.

At each chosen bit the block raises a one-cycle request strobe to the HDLC source and forwards the HDLC bit offered in that same cycle. Every other bit carries the payload unchanged. One instance serves one insertion channel. A link with several channels uses one instance per channel, each with its own settings. New settings are taken only at a frame-sync pulse, so a frame is never partly reconfigured.

Top module: `tdm_slot_inserter`

## Requirements
- R1: After reset and until the first frame-sync pulse, `hdlc_req_o` is 0 and `ser_o` equals `payload_i`, whatever the configuration inputs hold.
- R2: In a frame whose latched enable is 0, `hdlc_req_o` stays 0 and `ser_o` equals `payload_i` on every bit.
- R3: Frame parity flips at every frame-sync pulse. The frame that starts at the first pulse after reset is even. An even frame can insert only when its latched even-select is 1, and an odd frame only when its latched odd-select is 1.
- R4: The bit position is 0 in the cycle where `fsync_i` is 1 and advances by one per cycle after that. Insertion happens only at positions whose timeslot (position divided by 8) equals the latched timeslot number.
- R5: Within a timeslot, the bit at offset k (offset 0 is sent first) is eligible only when mask bit 7-k is 1.
- R6: At an eligible position, `hdlc_req_o` is 1 for that single cycle and `ser_o` equals `hdlc_bit_i` of the same cycle. At all other positions `hdlc_req_o` is 0 and `ser_o` equals `payload_i`.
- R7: Enable, both frame selects, the timeslot number and the mask are sampled in the cycle where `fsync_i` is 1. That cycle already uses the new values, and they hold until the next pulse. Changes at any other time have no effect on the current frame.
- R8: A frame-sync pulse restarts the position at 0 from any point. With no pulse, the position wraps from the last bit of the frame back to 0 without flipping the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| fsync_i | input | 1 | Frame-sync pulse marking position 0 |
| payload_i | input | 1 | Payload serial bit |
| hdlc_bit_i | input | 1 | HDLC bit offered by the transmitter |
| cfg_en_i | input | 1 | Channel enable |
| cfg_even_i | input | 1 | Allow insertion in even frames |
| cfg_odd_i | input | 1 | Allow insertion in odd frames |
| cfg_slot_i | input | 5 | Timeslot that carries HDLC bits |
| cfg_mask_i | input | 8 | Per-bit enable mask; bit 7 is the first bit sent |
| hdlc_req_o | output | 1 | One-cycle request for the next HDLC bit |
| ser_o | output | 1 | Outgoing serial bit |

## Verification
The bench builds the block with 4 timeslots of 8 bits, so one frame is 32 bit clocks. At that size every one of the 256 masks can be applied under all four frame-select combinations, with the timeslot rotating through all four values, in about 33 thousand cycles. Between pulses the bench drives scrambled settings, so each frame also tests that settings are held from the pulse. Short frames and frames with no pulse fit in a few hundred cycles and cover the restart and wrap cases.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  // Timeslot index of a bit position counted from the frame-sync bit.
  function automatic int unsigned slot_of(int unsigned pos, int unsigned bits_per_slot);
    return pos / bits_per_slot;
  endfunction

  // Offset of a bit inside its timeslot; offset 0 is sent first.
  function automatic int unsigned offset_of(int unsigned pos, int unsigned bits_per_slot);
    return pos % bits_per_slot;
  endfunction

  // Mask lookup: the first bit sent maps to the highest mask bit.
  function automatic logic mask_allows(int unsigned mask, int unsigned offset,
                                       int unsigned bits_per_slot);
    return ((mask >> (bits_per_slot - 1 - offset)) & 1) != 0;
  endfunction

  // Frame parity acceptance.
  function automatic logic parity_allows(logic odd_frame, logic take_even, logic take_odd);
    return odd_frame ? take_odd : take_even;
  endfunction

  // Next position, with wrap at the end of the frame.
  function automatic int unsigned next_position(int unsigned pos, int unsigned frame_bits);
    return (pos + 1) % frame_bits;
  endfunction

endpackage

// File: rtl/tsi_position_ctr.sv
module tsi_position_ctr #(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic [POS_W-1:0] pos_o,
  output logic             odd_o,
  output logic             live_o
);
  import tsi_pkg::*;

  logic [POS_W-1:0] pos_q;
  logic             odd_q;
  logic             live_q;

  // Current-cycle view: the sync bit is position 0 of a fresh frame.
  assign pos_o  = fsync_i ? '0 : pos_q;
  assign odd_o  = fsync_i ? ~odd_q : odd_q;
  assign live_o = fsync_i | live_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      odd_q  <= 1'b1;   // first pulse flips this to even
      live_q <= 1'b0;
    end else begin
      pos_q  <= POS_W'(next_position(int'(pos_o), FRAME_BITS));
      odd_q  <= odd_o;
      live_q <= live_o;
    end
  end

  // R8
  fsync_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> (pos_q == POS_W'(1)));

  // R8
  count_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsync_i |=> (pos_q == $past(pos_q) + POS_W'(1)));

  // R3
  parity_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> (odd_q != $past(odd_q)));

  // R3
  parity_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsync_i |=> $stable(odd_q));

endmodule

// File: rtl/tsi_cfg_hold.sv
module tsi_cfg_hold #(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned BITS   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              en_i,
  input  logic              even_i,
  input  logic              odd_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BITS-1:0]   mask_i,
  output logic              en_o,
  output logic              even_o,
  output logic              odd_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BITS-1:0]   mask_o
);
  logic              en_q;
  logic              even_q;
  logic              odd_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BITS-1:0]   mask_q;

  // The sync cycle already runs with the values being latched.
  assign en_o   = fsync_i ? en_i   : en_q;
  assign even_o = fsync_i ? even_i : even_q;
  assign odd_o  = fsync_i ? odd_i  : odd_q;
  assign slot_o = fsync_i ? slot_i : slot_q;
  assign mask_o = fsync_i ? mask_i : mask_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      even_q <= 1'b0;
      odd_q  <= 1'b0;
      slot_q <= '0;
      mask_q <= '0;
    end else if (fsync_i) begin
      en_q   <= en_i;
      even_q <= even_i;
      odd_q  <= odd_i;
      slot_q <= slot_i;
      mask_q <= mask_i;
    end
  end

  // R7
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsync_i |=> $stable({en_q, even_q, odd_q, slot_q, mask_q}));

endmodule

// File: rtl/tsi_slot_match.sv
module tsi_slot_match #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned BITS  = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned BIT_W  = $clog2(BITS),
  localparam int unsigned POS_W  = SLOT_W + BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              odd_frame_i,
  input  logic              live_i,
  input  logic              en_i,
  input  logic              take_even_i,
  input  logic              take_odd_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BITS-1:0]   mask_i,
  output logic              hit_o
);
  import tsi_pkg::*;

  logic [SLOT_W-1:0] cur_slot;
  logic [BIT_W-1:0]  cur_off;
  logic [BITS-1:0]   bit_hit;
  logic              slot_ok;
  logic              frame_ok;

  assign cur_slot = SLOT_W'(slot_of(int'(pos_i), BITS));
  assign cur_off  = BIT_W'(offset_of(int'(pos_i), BITS));
  assign slot_ok  = (cur_slot == slot_i);
  assign frame_ok = parity_allows(odd_frame_i, take_even_i, take_odd_i);

  // One lane per bit offset inside the timeslot.
  for (genvar k = 0; k < BITS; k++) begin : g_lane
    assign bit_hit[k] = (cur_off == BIT_W'(k)) & mask_allows(int'(mask_i), k, BITS);
  end

  assign hit_o = live_i & en_i & frame_ok & slot_ok & (|bit_hit);

  // R5
  lane_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bit_hit));

  // R3
  parity_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (odd_frame_i ? take_odd_i : take_even_i));

endmodule

// File: rtl/tdm_slot_inserter.sv
module tdm_slot_inserter #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned BITS  = 8,
  localparam int unsigned SLOT_W     = $clog2(SLOTS),
  localparam int unsigned BIT_W      = $clog2(BITS),
  localparam int unsigned FRAME_BITS = SLOTS * BITS,
  localparam int unsigned POS_W      = SLOT_W + BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              payload_i,
  input  logic              hdlc_bit_i,
  input  logic              cfg_en_i,
  input  logic              cfg_even_i,
  input  logic              cfg_odd_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic [BITS-1:0]   cfg_mask_i,
  output logic              hdlc_req_o,
  output logic              ser_o
);
  // Named internal events, visible to the assertions below.
  logic [POS_W-1:0]  pos;
  logic              odd_frame;
  logic              live;
  logic              eff_en;
  logic              eff_even;
  logic              eff_odd;
  logic [SLOT_W-1:0] eff_slot;
  logic [BITS-1:0]   eff_mask;
  logic              hit;

  tsi_position_ctr #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .pos_o   (pos),
    .odd_o   (odd_frame),
    .live_o  (live)
  );

  tsi_cfg_hold #(.SLOT_W(SLOT_W), .BITS(BITS)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .en_i    (cfg_en_i),
    .even_i  (cfg_even_i),
    .odd_i   (cfg_odd_i),
    .slot_i  (cfg_slot_i),
    .mask_i  (cfg_mask_i),
    .en_o    (eff_en),
    .even_o  (eff_even),
    .odd_o   (eff_odd),
    .slot_o  (eff_slot),
    .mask_o  (eff_mask)
  );

  tsi_slot_match #(.SLOTS(SLOTS), .BITS(BITS)) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pos_i       (pos),
    .odd_frame_i (odd_frame),
    .live_i      (live),
    .en_i        (eff_en),
    .take_even_i (eff_even),
    .take_odd_i  (eff_odd),
    .slot_i      (eff_slot),
    .mask_i      (eff_mask),
    .hit_o       (hit)
  );

  assign hdlc_req_o = hit;
  assign ser_o      = hit ? hdlc_bit_i : payload_i;

  // R1
  unsynced_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |-> !hdlc_req_o);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eff_en |-> (!hdlc_req_o && ser_o == payload_i));

  // R4
  slot_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdlc_req_o |-> (pos[POS_W-1:BIT_W] == eff_slot));

  // R6
  request_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdlc_req_o |-> (ser_o == hdlc_bit_i));

endmodule

// File: tb/tb_tdm_slot_inserter.sv
module tb_tdm_slot_inserter;
  localparam int SLOTS = 4;
  localparam int BITS  = 8;
  localparam int FRAME = SLOTS * BITS;
  localparam int SW    = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0, payload = 1'b0, hbit = 1'b0;
  logic en = 1'b0, ev = 1'b0, od = 1'b0;
  logic [SW-1:0]   ts = '0;
  logic [BITS-1:0] mask = '0;
  logic req, ser;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Bench model state
  int  m_pos  = 0;
  bit  m_odd  = 1;
  bit  m_live = 0;
  bit  m_en = 0, m_ev = 0, m_od = 0;
  int  m_ts = 0, m_mask = 0;

  always #5 clk = ~clk;

  tdm_slot_inserter #(.SLOTS(SLOTS), .BITS(BITS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .payload_i(payload),
    .hdlc_bit_i(hbit), .cfg_en_i(en), .cfg_even_i(ev), .cfg_odd_i(od),
    .cfg_slot_i(ts), .cfg_mask_i(mask), .hdlc_req_o(req), .ser_o(ser)
  );

  function automatic string reason(bit live, bit e, bit par_ok, bit slot_ok, bit exp_req);
    if (exp_req)   return "R6";
    if (!live)     return "R1";
    if (!e)        return "R2";
    if (!par_ok)   return "R3";
    if (!slot_ok)  return "R4";
    return "R5";
  endfunction

  // One bit clock: drive at the falling edge, check before the rising edge.
  task automatic step(input bit r, input bit fs, input bit e, input bit ve, input bit vo,
                      input int t, input int mk, input string extra);
    bit c_live, c_odd, c_en, c_ev, c_od, par_ok, slot_ok, mbit, exp_req, exp_ser;
    int c_pos, c_ts, c_mask;
    @(negedge clk);
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rst_n   = r;
    fsync   = fs;
    payload = lfsr[0];
    hbit    = lfsr[7];
    en = e; ev = ve; od = vo;
    ts   = SW'(t);
    mask = BITS'(mk);
    #2;
    if (!r) begin
      c_live = 0; c_pos = 0; c_odd = 1; c_en = 0; c_ev = 0; c_od = 0; c_ts = 0; c_mask = 0;
    end else begin
      c_live = fs | m_live;
      c_pos  = fs ? 0 : m_pos;
      c_odd  = fs ? !m_odd : m_odd;
      c_en   = fs ? e  : m_en;
      c_ev   = fs ? ve : m_ev;
      c_od   = fs ? vo : m_od;
      c_ts   = fs ? (t % SLOTS) : m_ts;
      c_mask = fs ? (mk % 256) : m_mask;
    end
    par_ok  = c_odd ? c_od : c_ev;
    slot_ok = (c_pos / BITS) == c_ts;
    mbit    = ((c_mask >> (BITS - 1 - (c_pos % BITS))) & 1) == 1;
    exp_req = r && c_live && c_en && par_ok && slot_ok && mbit;
    exp_ser = exp_req ? hbit : payload;
    vectors++;
    if (req !== exp_req || ser !== exp_ser) begin
      fails++;
      $display("FAIL %s%s pos=%0d req=%b ser=%b expected req=%b ser=%b",
               reason(c_live, c_en, par_ok, slot_ok, exp_req), extra, c_pos,
               req, ser, exp_req, exp_ser);
    end
    if (!r) begin
      m_pos = 0; m_odd = 1; m_live = 0; m_en = 0; m_ev = 0; m_od = 0; m_ts = 0; m_mask = 0;
    end else begin
      m_live = c_live; m_odd = c_odd; m_pos = (c_pos + 1) % FRAME;
      m_en = c_en; m_ev = c_ev; m_od = c_od; m_ts = c_ts; m_mask = c_mask;
    end
  endtask

  // One frame: settings offered on the pulse, scrambled settings elsewhere (R7).
  task automatic frame(input int len, input bit e, input bit ve, input bit vo,
                       input int t, input int mk);
    step(1, 1, e, ve, vo, t, mk, "");
    for (int i = 1; i < len; i++)
      step(1, 0, lfsr[3], !ve, !vo, t + 1, ~mk, " R7");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then no insertion before the first pulse
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, 0, 8'hFF, "");
    for (int i = 0; i < 40; i++) step(1, 0, 1, 1, 1, i % SLOTS, 8'hFF, " R1");
    // R3 R4 R5 R6 R7: all masks, all frame-select pairs, rotating timeslot
    for (int m = 0; m < 256; m++)
      for (int p = 0; p < 4; p++)
        frame(FRAME, 1, p[0], p[1], (m + p) % SLOTS, m);
    // R2: enable low suppresses everything
    for (int f = 0; f < 64; f++) frame(FRAME, 0, 1, 1, f % SLOTS, 8'hFF);
    // R8: short frames restart the position early
    for (int f = 0; f < 12; f++) frame(13, 1, 1, 1, 1, 8'hFF);
    // R8: no pulse, position wraps and parity holds
    step(1, 1, 1, 1, 0, 3, 8'h81, " R8");
    for (int i = 1; i < 3 * FRAME; i++) step(1, 0, 0, 0, 1, 0, 8'h00, " R8");
    frame(FRAME, 1, 0, 1, 2, 8'h3C);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule